// File: doc/BRIEF.md
# Partitioned SIMD Packed Adder

This block is one 32-bit adder that can be split at run time into narrower lanes that work independently. A two-bit lane-mode input selects the split: one 32-bit lane, two 16-bit lanes or four 8-bit lanes. The operand and result words are always a full 32 bits. A single transfer therefore carries one wide value, two halves or four bytes. The carry chain is built from byte slices. At every byte boundary that is also a lane boundary in the current mode, the carry out of the lower slice is discarded. In its place the upper slice receives the lane's own carry-in.

A subtract control turns every active lane into `A - B` by inverting operand B and injecting a carry-in of 1 at the bottom of each lane. Each lane reports its carry-out on the flag bit at the top byte of that lane. Results and flags are captured in one output register stage. A valid strobe travels alongside them with one cycle of latency.

Top module: `simd_packed_adder`

## Requirements
- R1: With `in_mode` = 2'b00 the result is `(A + B) mod 2^32`, and `out_flags[3]` is the carry out of bit 31.
- R2: With `in_mode` = 2'b01 the word is treated as two 16-bit lanes (bits 15:0 and 31:16). Each lane result is its own sum mod 2^16, and no carry passes from bit 15 into bit 16. `out_flags[1]` and `out_flags[3]` are the lane carry-outs.
- R3: With `in_mode` = 2'b10 the word is treated as four 8-bit lanes (byte k = bits 8k+7:8k). Each lane result is its own sum mod 2^8, and no carry crosses any byte boundary. `out_flags[k]` is the carry-out of byte k.
- R4: `in_mode` = 2'b11 gives the same results and flags as 2'b10.
- R5: With `in_sub` = 1, every active lane computes `A + ~B + 1` mod its width. Its flag is then 1 exactly when A >= B as unsigned lane values, and 0 on a borrow.
- R6: Flag bits that are not the top byte of an active lane read 0: bits 2:0 in 32-bit mode, and bits 2 and 0 in 16-bit mode.
- R7: `out_valid` is 1 in the cycle after a clock edge that samples `in_valid` = 1, and 0 otherwise. The result and flags of that operation appear in the same cycle.
- R8: An edge that samples `in_valid` = 0 leaves `out_result` and `out_flags` unchanged, whatever the other inputs are.
- R9: Synchronous active-high `rst` clears `out_result`, `out_flags` and `out_valid` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | Lane split: 00 one 32-bit lane, 01 two 16-bit lanes, 10 and 11 four 8-bit lanes |
| in_sub | input | 1 | 1 selects subtraction in every lane |
| in_a | input | 32 | Packed operand A |
| in_b | input | 32 | Packed operand B |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| out_result | output | 32 | Packed lane results |
| out_flags | output | 4 | Per-byte carry-out flags, meaningful at the top byte of each lane |

## Verification
The hardest case to reach is a carry that would cross a lane boundary. Random operands rarely produce one, and the result looks right unless the lower lane actually generates a carry at that exact byte. The stimulus therefore uses operands that saturate a lane, such as 0x000000FF + 1 and 0x0000FFFF + 1. It applies the same pair in every mode, so the same carry must be propagated in one mode and cut in another. Subtraction of equal and of smaller-minuend lanes applies the same test to the injected carry-in, and the borrow flag is checked in each lane.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    SPLIT_W32  = 2'b00,
    SPLIT_W16  = 2'b01,
    SPLIT_W8   = 2'b10,
    SPLIT_RSVD = 2'b11
  } split_e;

  // Number of byte slices that make up one lane in the given split.
  function automatic int lane_bytes(input logic [1:0] mode, input int nbytes);
    case (split_e'(mode))
      SPLIT_W32: lane_bytes = nbytes;
      SPLIT_W16: lane_bytes = nbytes / 2;
      default:   lane_bytes = 1;
    endcase
  endfunction

  // Arithmetic of one slice: {carry, sum} of a + (b ^ inv) + cin.
  function automatic logic [8:0] slice_add(input logic [7:0] a, input logic [7:0] b,
                                           input logic inv, input logic cin);
    slice_add = {1'b0, a} + {1'b0, b ^ {8{inv}}} + {8'd0, cin};
  endfunction

endpackage

// File: rtl/spa_lane_ctrl.sv
module spa_lane_ctrl #(
  parameter int NUM_BYTES = 4
) (
  input  logic [1:0]           mode,
  output logic [NUM_BYTES-1:0] start_mask,
  output logic [NUM_BYTES-1:0] top_mask
);
  int lb_w;
  assign lb_w = spa_pkg::lane_bytes(mode, NUM_BYTES);

  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      start_mask[i] = ((i % lb_w) == 0);
      top_mask[i]   = ((i % lb_w) == (lb_w - 1));
    end
  end
endmodule

// File: rtl/spa_slice_chain.sv
module spa_slice_chain #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  input  logic                 sub,
  input  logic [NUM_BYTES-1:0] start_mask,
  output logic [DATA_W-1:0]    sum,
  output logic [NUM_BYTES-1:0] byte_cout,
  output logic [NUM_BYTES-1:0] slice_cin
);
  logic [NUM_BYTES:0] ripple;
  assign ripple[0] = sub;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
    logic [BYTE_W-1:0] a_s, b_s;
    logic [BYTE_W:0]   tot;
    assign slice_cin[g] = start_mask[g] ? sub : ripple[g];
    assign a_s = a[g*BYTE_W +: BYTE_W];
    assign b_s = b[g*BYTE_W +: BYTE_W] ^ {BYTE_W{sub}};
    assign tot = {1'b0, a_s} + {1'b0, b_s} + {{BYTE_W{1'b0}}, slice_cin[g]};
    assign sum[g*BYTE_W +: BYTE_W] = tot[BYTE_W-1:0];
    assign ripple[g+1] = tot[BYTE_W];
  end

  assign byte_cout = ripple[NUM_BYTES:1];
endmodule

// File: rtl/spa_out_reg.sv
module spa_out_reg #(
  parameter int DATA_W  = 32,
  parameter int FLAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [DATA_W-1:0] d_sum,
  input  logic [FLAG_W-1:0] d_flags,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_sum,
  output logic [FLAG_W-1:0] q_flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_sum   <= '0;
      q_flags <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_sum   <= d_sum;
        q_flags <= d_flags;
      end
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> ($stable(q_sum) && $stable(q_flags)));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (q_sum == '0 && q_flags == '0 && !q_valid));
endmodule

// File: rtl/simd_packed_adder.sv
module simd_packed_adder #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  localparam int DATA_W   = BYTE_W * NUM_BYTES,
  localparam int HALF_W   = DATA_W / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic                 in_sub,
  input  logic [DATA_W-1:0]    in_a,
  input  logic [DATA_W-1:0]    in_b,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_result,
  output logic [NUM_BYTES-1:0] out_flags
);
  logic [NUM_BYTES-1:0] start_mask, top_mask;
  logic [NUM_BYTES-1:0] byte_cout, slice_cin;
  logic [DATA_W-1:0]    raw_sum;
  logic [NUM_BYTES-1:0] lane_flags;

  spa_lane_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .mode(in_mode), .start_mask(start_mask), .top_mask(top_mask)
  );

  spa_slice_chain #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chain (
    .a(in_a), .b(in_b), .sub(in_sub), .start_mask(start_mask),
    .sum(raw_sum), .byte_cout(byte_cout), .slice_cin(slice_cin)
  );

  assign lane_flags = byte_cout & top_mask;

  spa_out_reg #(.DATA_W(DATA_W), .FLAG_W(NUM_BYTES)) u_oreg (
    .clk(clk), .rst(rst), .d_valid(in_valid), .d_sum(raw_sum), .d_flags(lane_flags),
    .q_valid(out_valid), .q_sum(out_result), .q_flags(out_flags)
  );

  // A lane start above byte 0 must see the lane carry-in, never the neighbour's carry.
  p_boundary_cut_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && start_mask[NUM_BYTES/2]) |-> (slice_cin[NUM_BYTES/2] == in_sub));

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_unused_flags_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_flags & ~$past(top_mask)) == '0));

  p_low_half_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b01) |=>
      (out_result[HALF_W-1:0] == ($past(in_a[HALF_W-1:0]) +
        ($past(in_b[HALF_W-1:0]) ^ {HALF_W{$past(in_sub)}}) + HALF_W'($past(in_sub)))));

  // Covers both 2'b10 and the reserved 2'b11 (R4).
  p_lane_cut_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode[1]) |=>
      (out_result[2*BYTE_W-1:BYTE_W] == ($past(in_a[2*BYTE_W-1:BYTE_W]) +
        ($past(in_b[2*BYTE_W-1:BYTE_W]) ^ {BYTE_W{$past(in_sub)}}) + BYTE_W'($past(in_sub)))));
endmodule

// File: tb/tb_simd_packed_adder.sv
`timescale 1ns/1ps
module tb_simd_packed_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic        in_sub = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [3:0]  out_flags;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  simd_packed_adder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_flags(out_flags)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference: lane-by-lane arithmetic on wide integers.
  task automatic ref_calc(input logic [31:0] a, input logic [31:0] b, input logic [1:0] mode,
                          input logic sub, output logic [31:0] res, output logic [3:0] fl);
    int w;
    longint mask, x, y, t;
    logic [31:0] bb;
    w = (mode == 2'b00) ? 32 : (mode == 2'b01) ? 16 : 8;
    mask = (64'd1 << w) - 1;
    bb = sub ? ~b : b;
    res = '0;
    fl = '0;
    for (int l = 0; l < 32 / w; l++) begin
      x = (longint'(a) >> (l * w)) & mask;
      y = (longint'(bb) >> (l * w)) & mask;
      t = x + y + (sub ? 1 : 0);
      res = res | 32'((t & mask) << (l * w));
      fl[(l + 1) * (w / 8) - 1] = t[w];
    end
  endtask

  logic [31:0] last_res;
  logic [3:0]  last_fl;

  task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b,
                    input logic [1:0] mode, input logic sub);
    logic [31:0] er;
    logic [3:0]  ef;
    ref_calc(a, b, mode, sub, er, ef);
    @(negedge clk);
    in_a = a; in_b = b; in_mode = mode; in_sub = sub; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    check({tag, " result"}, out_result, er);
    check({tag, " flags"}, {28'd0, out_flags}, {28'd0, ef});
    check({tag, " R7 valid"}, {31'd0, out_valid}, 32'd1);
    last_res = er;
    last_fl  = ef;
  endtask

  task automatic t_reset;
    check("R9 reset result", out_result, 32'd0);
    check("R9 reset flags", {28'd0, out_flags}, 32'd0);
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_w32;
    op("R1 w32 simple", 32'h1234_5678, 32'h1111_1111, 2'b00, 1'b0);
    op("R1 w32 byte carry", 32'h0000_00FF, 32'h0000_0001, 2'b00, 1'b0);
    op("R1 w32 wrap", 32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0);
    check("R6 w32 unused flags", {29'd0, out_flags[2:0]}, 32'd0);
  endtask

  task automatic t_w16;
    op("R2 w16 cut at 16", 32'h0000_FFFF, 32'h0000_0001, 2'b01, 1'b0);
    op("R2 w16 both carry", 32'hFFFF_8000, 32'h0001_8000, 2'b01, 1'b0);
    check("R6 w16 unused flags", {30'd0, out_flags[2], out_flags[0]}, 32'd0);
    op("R2 w16 byte carry kept", 32'h00FF_00FF, 32'h0001_0001, 2'b01, 1'b0);
  endtask

  task automatic t_w8;
    op("R3 w8 cut at 8", 32'h0000_00FF, 32'h0000_0001, 2'b10, 1'b0);
    op("R3 w8 all carry", 32'hFFFF_FFFF, 32'h0101_0101, 2'b10, 1'b0);
    op("R3 w8 mixed", 32'h80_7F_10_F0, 32'h80_01_20_20, 2'b10, 1'b0);
  endtask

  task automatic t_rsvd;
    op("R4 rsvd cut", 32'h0000_00FF, 32'h0000_0001, 2'b11, 1'b0);
    op("R4 rsvd mixed", 32'h80_7F_10_F0, 32'h80_01_20_20, 2'b11, 1'b0);
    op("R4 rsvd sub", 32'h05_00_FF_10, 32'h06_00_01_10, 2'b11, 1'b1);
  endtask

  task automatic t_sub;
    op("R5 sub w32 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b00, 1'b1);
    op("R5 sub w32 borrow", 32'h0000_0001, 32'h0000_0002, 2'b00, 1'b1);
    op("R5 sub w16", 32'h0001_0000, 32'h0002_0001, 2'b01, 1'b1);
    op("R5 sub w8", 32'h10_00_FF_03, 32'h10_01_00_05, 2'b10, 1'b1);
  endtask

  task automatic t_hold;
    @(negedge clk);
    in_a = 32'hAAAA_5555; in_b = 32'h1234_4321; in_mode = 2'b10; in_sub = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R8 hold result", out_result, last_res);
    check("R8 hold flags", {28'd0, out_flags}, {28'd0, last_fl});
    check("R7 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset_mid;
    op("R1 before reset", 32'h0F0F_0F0F, 32'h0101_0101, 2'b00, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_w32();
    t_w16();
    t_w8();
    t_rsvd();
    t_sub();
    t_hold();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule